// File: doc/BRIEF.md
# Chainable Synchronous FIFO Stage

This block is one storage stage of a first-in, first-out queue that is built to be placed several times in a row, so that a handful of small stages act as one deeper queue. Each stage holds `DEPTH` words of `DW` bits in a memory with pointers and an occupancy counter. A parameter gives the stage its place in the row: the head stage takes writes from the user, inner stages only pass words along, and the tail stage offers the oldest word to the user for reading. A fourth setting makes the stage a standalone queue with a write port and a read port and no link to any neighbour.

Two wires connect neighbouring stages. An empty flag runs downstream. A pull strobe runs upstream. A stage that is not full and sees its upstream neighbour non-empty raises the pull strobe. On that clock edge the upstream stage drops its oldest word and the downstream stage stores it. No word is lost or copied. Words move through the row at one per cycle per link, in the order they were written. A row of three stages holds three times the stage depth.

Top module: `chain_fifo_stage`

## Requirements
- R1: Synchronous reset (active high) empties the stage: `full_o` low, `dn_empty_o` high and `rd_empty_o` high from the first edge after reset is released.
- R2: A stage that takes user writes (role code 0 head, or 3 standalone) stores `wr_data_i` on an edge where `wr_en_i` is high and `full_o` is low. A write offered while `full_o` is high is dropped, even when a read happens on the same edge.
- R3: An inner (code 1) or tail (code 2) stage drives `up_rd_o` high exactly when `up_empty_i` is low and its own `full_o` is low. On that edge it stores `up_data_i`.
- R4: A head or inner stage drives `dn_empty_o` equal to its own empty state and `dn_data_o` with its oldest word. It drops that word on an edge where `dn_rd_i` is high.
- R5: Words leave the tail of a head–inner–tail row in write order, with none lost or duplicated, under any mix of writes and reads.
- R6: With no reads, a row of three stages accepts exactly `3*DEPTH` writes before the head raises `full_o`, and then every stage reports full.
- R7: A tail or standalone stage shows its oldest word on `rd_data_o` while `rd_empty_o` is low. That word and the flag stay unchanged until `rd_en_i` is high. A read while `rd_empty_o` is high is ignored.
- R8: A stage never reports full and empty together. A store and a drop on the same edge leave its occupancy unchanged.
- R9: In standalone mode (code 3) the cascade signals are inert: `up_rd_o` stays low, `dn_empty_o` stays high, and `dn_rd_i` and `up_empty_i` have no effect.
- R10: A word written into an empty three-stage row is stored by the head on that edge. `rd_empty_o` of the tail falls after the second edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | User write strobe (head and standalone only) |
| wr_data_i | input | DW | User write word |
| full_o | output | 1 | Stage is full |
| up_empty_i | input | 1 | Empty flag of the upstream stage |
| up_data_i | input | DW | Oldest word of the upstream stage |
| up_rd_o | output | 1 | Pull strobe to the upstream stage |
| dn_rd_i | input | 1 | Pull strobe from the downstream stage |
| dn_empty_o | output | 1 | Empty flag toward the downstream stage |
| dn_data_o | output | DW | Oldest word toward the downstream stage |
| rd_en_i | input | 1 | User read strobe (tail and standalone only) |
| rd_data_o | output | DW | Oldest word for the user |
| rd_empty_o | output | 1 | User-side empty flag |

## Verification
Each result has a fixed due time:
- The flags come from the occupancy counter, so they change one edge after a store or a drop.
- `up_rd_o` follows its inputs within the same cycle.
- A new word reaches the tail's output two edges after the head stores it.

The bench drives inputs on the falling edge and samples just before the next falling edge, after every register has updated. The cycle-count checks are placed on those exact edges: the head's empty flag one edge after a write, the tail's flag still high after one edge and low after two. Each read is checked against a reference queue at the moment the read is issued.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;
  typedef enum logic [1:0] {
    ROLE_HEAD  = 2'd0,
    ROLE_INNER = 2'd1,
    ROLE_TAIL  = 2'd2,
    ROLE_SOLO  = 2'd3
  } stage_role_e;

  function automatic bit role_pulls(stage_role_e r);
    return (r == ROLE_INNER) || (r == ROLE_TAIL);
  endfunction

  function automatic bit role_feeds(stage_role_e r);
    return (r == ROLE_HEAD) || (r == ROLE_INNER);
  endfunction
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
endmodule

// File: rtl/stage_intake.sv
module stage_intake
  import casc_fifo_pkg::*;
#(
  parameter stage_role_e ROLE = ROLE_SOLO,
  parameter int          DW   = 8
) (
  input  logic          full,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          up_empty,
  input  logic [DW-1:0] up_data,
  output logic          up_rd,
  output logic          push,
  output logic [DW-1:0] push_data
);
  logic unused_intake;
  assign unused_intake = ^{wr_en, wr_data, up_empty, up_data};

  if (role_pulls(ROLE)) begin : g_pull
    // pull a word whenever upstream has one and there is room here
    assign up_rd     = !up_empty && !full;
    assign push      = up_rd;
    assign push_data = up_data;
  end else begin : g_user
    assign up_rd     = 1'b0;
    assign push      = wr_en && !full;
    assign push_data = wr_data;
  end
endmodule

// File: rtl/stage_outlet.sv
module stage_outlet
  import casc_fifo_pkg::*;
#(
  parameter stage_role_e ROLE = ROLE_SOLO,
  parameter int          DW   = 8
) (
  input  logic          empty,
  input  logic [DW-1:0] head_data,
  input  logic          dn_rd,
  input  logic          rd_en,
  output logic          pop,
  output logic          dn_empty,
  output logic [DW-1:0] dn_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  logic unused_outlet;
  assign unused_outlet = ^{dn_rd, rd_en};

  if (role_feeds(ROLE)) begin : g_feed
    assign pop      = dn_rd && !empty;
    assign dn_empty = empty;
    assign dn_data  = head_data;
    assign rd_data  = '0;
    assign rd_empty = 1'b1;
  end else begin : g_serve
    assign pop      = rd_en && !empty;
    assign dn_empty = 1'b1;
    assign dn_data  = '0;
    assign rd_data  = head_data;
    assign rd_empty = empty;
  end
endmodule

// File: rtl/chain_fifo_stage.sv
module chain_fifo_stage
  import casc_fifo_pkg::*;
#(
  parameter stage_role_e ROLE  = ROLE_SOLO,
  parameter int          DW    = 8,
  parameter int          DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          up_empty_i,
  input  logic [DW-1:0] up_data_i,
  output logic          up_rd_o,
  input  logic          dn_rd_i,
  output logic          dn_empty_o,
  output logic [DW-1:0] dn_data_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_empty_o
);
  logic          push, pop, empty;
  logic [DW-1:0] push_data, head_data;

  stage_intake #(.ROLE(ROLE), .DW(DW)) u_intake (
    .full      (full_o),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .up_empty  (up_empty_i),
    .up_data   (up_data_i),
    .up_rd     (up_rd_o),
    .push      (push),
    .push_data (push_data)
  );

  fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .full      (full_o),
    .empty     (empty)
  );

  stage_outlet #(.ROLE(ROLE), .DW(DW)) u_outlet (
    .empty     (empty),
    .head_data (head_data),
    .dn_rd     (dn_rd_i),
    .rd_en     (rd_en_i),
    .pop       (pop),
    .dn_empty  (dn_empty_o),
    .dn_data   (dn_data_o),
    .rd_data   (rd_data_o),
    .rd_empty  (rd_empty_o)
  );
endmodule

// File: rtl/chain_fifo_stage_chk.sv
module chain_fifo_stage_chk
  import casc_fifo_pkg::*;
#(
  parameter stage_role_e ROLE = ROLE_SOLO,
  parameter int          DW   = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          full_o,
  input logic          up_empty_i,
  input logic          up_rd_o,
  input logic          dn_rd_i,
  input logic          dn_empty_o,
  input logic          rd_en_i,
  input logic          rd_empty_o,
  input logic [DW-1:0] rd_data_o
);
  logic own_empty;
  logic unused_chk;
  assign unused_chk = ^{rd_data_o, dn_rd_i, rd_en_i};
  assign own_empty  = role_feeds(ROLE) ? dn_empty_o : rd_empty_o;

  // R1: reset leaves the stage not full and empty
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!full_o && own_empty));

  // R3: a pull is only raised with data upstream and room here
  a_r3_pull_guard: assert property (@(posedge clk) disable iff (rst)
    up_rd_o |-> (!up_empty_i && !full_o));

  // R8: full and empty are exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full_o && own_empty));

  if (role_feeds(ROLE)) begin : g_feed_chk
    // R4: words are only dropped on a downstream pull
    a_r4_hold_unpulled: assert property (@(posedge clk) disable iff (rst)
      (!dn_empty_o && !dn_rd_i) |=> !dn_empty_o);
  end else begin : g_serve_chk
    // R7: oldest word held steady until read
    a_r7_head_stable: assert property (@(posedge clk) disable iff (rst)
      (!rd_empty_o && !rd_en_i) |=> (!rd_empty_o && $stable(rd_data_o)));
  end

  if (ROLE == ROLE_SOLO) begin : g_solo_chk
    // R9: cascade signals inert in standalone mode
    a_r9_solo_inert: assert property (@(posedge clk) disable iff (rst)
      (!up_rd_o && dn_empty_o));
  end
endmodule

bind chain_fifo_stage chain_fifo_stage_chk #(.ROLE(ROLE), .DW(DW)) u_chk (.*);

// File: tb/chain_fifo_stage_test.sv
`timescale 1ns/1ps
module chain_fifo_stage_test;
  import casc_fifo_pkg::*;

  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int CAP   = 3 * DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // chain signals
  logic          h_wr_en, h_full, h_up_rd, h_dn_empty, h_rd_empty;
  logic [DW-1:0] h_wr_data, h_dn_data, h_rd_data;
  logic          m_full, m_up_rd, m_dn_empty, m_rd_empty;
  logic [DW-1:0] m_dn_data, m_rd_data;
  logic          t_full, t_up_rd, t_dn_empty, t_rd_en, t_rd_empty;
  logic [DW-1:0] t_dn_data, t_rd_data;
  // standalone signals
  logic          s_wr_en, s_full, s_up_empty, s_up_rd, s_dn_rd, s_dn_empty, s_rd_en, s_rd_empty;
  logic [DW-1:0] s_wr_data, s_dn_data, s_rd_data;

  chain_fifo_stage #(.ROLE(ROLE_HEAD), .DW(DW), .DEPTH(DEPTH)) u_head (
    .clk(clk), .rst(rst), .wr_en_i(h_wr_en), .wr_data_i(h_wr_data), .full_o(h_full),
    .up_empty_i(1'b1), .up_data_i('0), .up_rd_o(h_up_rd), .dn_rd_i(m_up_rd),
    .dn_empty_o(h_dn_empty), .dn_data_o(h_dn_data), .rd_en_i(1'b0),
    .rd_data_o(h_rd_data), .rd_empty_o(h_rd_empty));

  chain_fifo_stage #(.ROLE(ROLE_INNER), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en_i(1'b0), .wr_data_i('0), .full_o(m_full),
    .up_empty_i(h_dn_empty), .up_data_i(h_dn_data), .up_rd_o(m_up_rd), .dn_rd_i(t_up_rd),
    .dn_empty_o(m_dn_empty), .dn_data_o(m_dn_data), .rd_en_i(1'b0),
    .rd_data_o(m_rd_data), .rd_empty_o(m_rd_empty));

  chain_fifo_stage #(.ROLE(ROLE_TAIL), .DW(DW), .DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst(rst), .wr_en_i(1'b0), .wr_data_i('0), .full_o(t_full),
    .up_empty_i(m_dn_empty), .up_data_i(m_dn_data), .up_rd_o(t_up_rd), .dn_rd_i(1'b0),
    .dn_empty_o(t_dn_empty), .dn_data_o(t_dn_data), .rd_en_i(t_rd_en),
    .rd_data_o(t_rd_data), .rd_empty_o(t_rd_empty));

  chain_fifo_stage #(.ROLE(ROLE_SOLO), .DW(DW), .DEPTH(DEPTH)) u_solo (
    .clk(clk), .rst(rst), .wr_en_i(s_wr_en), .wr_data_i(s_wr_data), .full_o(s_full),
    .up_empty_i(s_up_empty), .up_data_i(16'hdead), .up_rd_o(s_up_rd), .dn_rd_i(s_dn_rd),
    .dn_empty_o(s_dn_empty), .dn_data_o(s_dn_data), .rd_en_i(s_rd_en),
    .rd_data_o(s_rd_data), .rd_empty_o(s_rd_empty));

  int n_checks = 0;
  int n_err    = 0;
  int n_reads  = 0;
  bit done     = 1'b0;
  logic [DW-1:0] model[$];
  logic [DW-1:0] smodel[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one chain cycle: check at the falling edge, then drive for the next rising edge
  task automatic step_chain(input bit want_wr, input logic [DW-1:0] wdata, input bit want_rd);
    @(negedge clk);
    chk(m_up_rd == (!h_dn_empty && !m_full), "R3 inner pull", m_up_rd, !h_dn_empty && !m_full);
    chk(t_up_rd == (!m_dn_empty && !t_full), "R3 tail pull", t_up_rd, !m_dn_empty && !t_full);
    if (want_rd && !t_rd_empty) begin
      if (model.size() == 0) chk(1'b0, "R5 word with empty reference", t_rd_data, 0);
      else begin
        chk(t_rd_data == model[0], "R5 order", t_rd_data, model[0]);
        void'(model.pop_front());
      end
      n_reads++;
    end
    h_wr_en   = want_wr;
    h_wr_data = wdata;
    t_rd_en   = want_rd;
    if (want_wr && !h_full) model.push_back(wdata);
  endtask

  task automatic step_solo(input bit want_wr, input logic [DW-1:0] wdata, input bit want_rd);
    @(negedge clk);
    chk(s_up_rd == 1'b0, "R9 solo up_rd", s_up_rd, 0);
    chk(s_dn_empty == 1'b1, "R9 solo dn_empty", s_dn_empty, 1);
    chk(!(s_full && s_rd_empty), "R8 solo flags", {s_full, s_rd_empty}, 0);
    if (want_rd && !s_rd_empty) begin
      if (smodel.size() == 0) chk(1'b0, "R7 solo word with empty reference", s_rd_data, 0);
      else begin
        chk(s_rd_data == smodel[0], "R7 solo order", s_rd_data, smodel[0]);
        void'(smodel.pop_front());
      end
    end
    s_wr_en    = want_wr;
    s_wr_data  = wdata;
    s_rd_en    = want_rd;
    s_dn_rd    = 1'($urandom);
    s_up_empty = 1'($urandom);
    if (want_wr && !s_full) smodel.push_back(wdata);
  endtask

  task automatic do_reset();
    h_wr_en = 0; h_wr_data = '0; t_rd_en = 0;
    s_wr_en = 0; s_wr_data = '0; s_rd_en = 0; s_dn_rd = 0; s_up_empty = 1;
    model.delete(); smodel.delete();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int drained;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(h_full == 0, "R1 head full", h_full, 0);
    chk(h_dn_empty == 1, "R1 head dn_empty", h_dn_empty, 1);
    chk(m_dn_empty == 1, "R1 inner dn_empty", m_dn_empty, 1);
    chk(t_rd_empty == 1, "R1 tail rd_empty", t_rd_empty, 1);
    chk(s_rd_empty == 1 && s_full == 0, "R1 solo flags", {s_full, s_rd_empty}, 1);
    chk(m_up_rd == 0 && t_up_rd == 0, "R1 pulls idle", {m_up_rd, t_up_rd}, 0);

    // R7: read on empty chain is ignored
    for (int i = 0; i < 5; i++) begin
      step_chain(1'b0, '0, 1'b1);
      chk(t_rd_empty == 1, "R7 read on empty", t_rd_empty, 1);
    end
    step_chain(1'b0, '0, 1'b0);

    // R10 and R4: latency of one word through an empty row
    h_wr_en = 1; h_wr_data = 16'h5a5a; model.push_back(16'h5a5a);
    @(negedge clk);
    h_wr_en = 0;
    chk(h_dn_empty == 0, "R4 head dn_empty after write", h_dn_empty, 0);
    chk(h_dn_data == 16'h5a5a, "R4 head dn_data", h_dn_data, 16'h5a5a);
    chk(t_rd_empty == 1, "R10 tail empty after 1 edge", t_rd_empty, 1);
    @(negedge clk);
    chk(t_rd_empty == 1, "R10 tail empty after 2 edges", t_rd_empty, 1);
    chk(h_dn_empty == 1, "R4 head drained by pull", h_dn_empty, 1);
    @(negedge clk);
    chk(t_rd_empty == 0, "R10 tail ready after 3 edges", t_rd_empty, 0);
    chk(t_rd_data == 16'h5a5a, "R10 tail data", t_rd_data, 16'h5a5a);
    step_chain(1'b0, '0, 1'b1);
    step_chain(1'b0, '0, 1'b0);
    chk(t_rd_empty == 1 && model.size() == 0, "R5 single word consumed", t_rd_empty, 1);

    // R6 and R2: fill the row with no reads
    for (int i = 0; i < 200; i++) step_chain(1'b1, DW'(i), 1'b0);
    step_chain(1'b0, '0, 1'b0);
    chk(model.size() == CAP, "R6 row capacity", model.size(), CAP);
    chk(h_full && m_full && t_full, "R6 all stages full", {h_full, m_full, t_full}, 7);
    chk(t_rd_data == 0, "R7 oldest word shown", t_rd_data, 0);
    // R2: writes offered while full must not appear in the drain
    n_reads = 0;
    for (int i = 0; i < CAP + 20; i++) step_chain(1'b0, '0, 1'b1);
    step_chain(1'b0, '0, 1'b0);
    chk(n_reads == CAP, "R2 blocked writes dropped", n_reads, CAP);
    chk(t_rd_empty == 1 && model.size() == 0, "R5 drain complete", model.size(), 0);

    // R5: random traffic in three phases
    for (int i = 0; i < 3000; i++) begin
      int ph;
      bit w;
      bit r;
      ph = (i / 250) % 3;
      w = (ph == 0) ? ($urandom_range(99) < 80) : (ph == 1) ? ($urandom_range(99) < 30) : ($urandom_range(99) < 50);
      r = (ph == 0) ? ($urandom_range(99) < 30) : (ph == 1) ? ($urandom_range(99) < 85) : ($urandom_range(99) < 50);
      step_chain(w, DW'($urandom), r);
    end
    drained = 0;
    while ((model.size() != 0 || !t_rd_empty) && drained < 400) begin
      step_chain(1'b0, '0, 1'b1);
      drained++;
    end
    step_chain(1'b0, '0, 1'b0);
    chk(model.size() == 0 && t_rd_empty == 1, "R5 random drain", model.size(), 0);

    // standalone stage: R8 and R9
    for (int i = 0; i < 3; i++) step_solo(1'b1, DW'(16'h100 + i), 1'b0);
    for (int i = 0; i < 10; i++) step_solo(1'b1, DW'(16'h200 + i), 1'b1);
    step_solo(1'b0, '0, 1'b0);
    chk(smodel.size() == 3 && s_rd_empty == 0, "R8 occupancy kept", smodel.size(), 3);
    for (int i = 0; i < 13; i++) step_solo(1'b1, DW'(16'h300 + i), 1'b0);
    step_solo(1'b0, '0, 1'b0);
    chk(s_full == 1, "R2 solo full", s_full, 1);
    // write offered while full together with a read: write dropped
    step_solo(1'b1, 16'hbeef, 1'b1);
    step_solo(1'b0, '0, 1'b0);
    chk(s_full == 0 && smodel.size() == DEPTH - 1, "R2 write while full dropped", smodel.size(), DEPTH - 1);
    while (!s_rd_empty) step_solo(1'b0, '0, 1'b1);
    step_solo(1'b0, '0, 1'b0);
    chk(smodel.size() == 0, "R9 solo drained in order", smodel.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule